// File: doc/BRIEF.md
# SDRAM Command-Mode Sequencer

This block drives the command and address pins of a single-data-rate SDRAM. It has no power-up state machine of its own. Software brings the device up by choosing a command type on the `mode` input and then making one dummy access to the memory window. That access issues exactly one command of the chosen type, or none, and then completes. A typical bring-up goes like this: one access in NOP mode, which starts the clock; one in precharge mode; eight in refresh mode; one in load-mode mode. Normal mode is selected last.

In normal mode each host access becomes an ACTIVE command followed by a single-beat READ or WRITE with auto-precharge. The row, column and bank are taken from the host byte address, using the geometry set on the configuration inputs. A refresh timer, once loaded, inserts a precharge-all and then an auto-refresh at a fixed interval. Every command is held back until the timing parameters of the commands before it allow it. The block also outputs the decoded device size in bytes.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset `sd_cke` is 0, `sd_cmd` is NOP (4'b0111) and `host_ready` is 0. Command encoding on `sd_cmd` = {cs_n, ras_n, cas_n, we_n}: PRE 0010, REF 0001, MRS 0000, ACT 0011, READ 0101, WRITE 0100.
- R2: Until the first access made with `mode`=1 (NOP), an access in any mode completes with a `host_ready` pulse, puts only NOP on the bus and leaves `sd_cke` at 0. That first NOP-mode access sets `sd_cke` to 1.
- R3: Once `sd_cke` is 1, each access issues one command chosen by `mode`: 1 gives none, 2 gives PRE with A10=1, 3 gives REF, 4 gives MRS. Eight accesses in mode 3 give eight REF commands.
- R4: MRS drives BA=0 and an address of CAS latency in A6..A4, with all other bits 0 (sequential burst of length 1).
- R5: Command spacing in clocks: PRE to the next command = tRP; REF to the next command = tRC; ACT to READ or WRITE = tRCD. From one ACT to the next ACT is at least max(tRC, tRAS+tRP), and from a WRITE to the next ACT is at least tWR+tRP. These spacings are exact when the host is waiting.
- R6: In normal mode (`mode`=0), the word address is the byte address shifted right by 2 (32-bit bus) or by 1 (16-bit bus). Its low C bits are the column, the next R bits are the row and the next B bits are the bank. C = 8+`cfg_col` (0..2), R = 11+`cfg_row` (0..2), B = 1+`cfg_bank`.
- R7: A normal write drives `sd_dq_out`=`host_wdata` with `sd_dq_oe`=1 only in the WRITE cycle. READ and WRITE carry A10=1 (auto-precharge).
- R8: A normal read returns the value of `sd_dq_in` sampled at the clock edge that is CL (`cfg_cas`) clocks after the edge that issued READ.
- R9: An access in a non-normal mode returns `host_rdata`=0.
- R10: With `ref_period` = P > 0 in normal mode, the block issues PRE (A10=1) and then, tRP later, REF. Successive refreshes on an idle bus are exactly P clocks apart.
- R11: `ref_period`=0 issues no automatic refresh.
- R12: `size_bytes` = 2^(R+C+B+1) when `cfg_dbw16`=1, otherwise 2^(R+C+B+2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode | input | 3 | Command type for the next access (0 normal, 1 NOP, 2 precharge, 3 refresh, 4 load mode) |
| cfg_col | input | 2 | Column bits minus 8 |
| cfg_row | input | 2 | Row bits minus 11 |
| cfg_bank | input | 1 | Bank bits minus 1 |
| cfg_dbw16 | input | 1 | 1 selects a 16-bit data bus |
| cfg_cas | input | 3 | CAS latency in clocks |
| cfg_twr | input | TW | tWR in clocks |
| cfg_trc | input | TW | tRC in clocks |
| cfg_trp | input | TW | tRP in clocks |
| cfg_trcd | input | TW | tRCD in clocks |
| cfg_tras | input | TW | tRAS in clocks |
| cfg_txsr | input | TW | Delay after clock enable in clocks |
| ref_period | input | RW | Clocks between automatic refreshes, 0 disables |
| host_sel | input | 1 | Access request, held until `host_ready` |
| host_we | input | 1 | 1 for write |
| host_addr | input | AW | Byte address in the window |
| host_wdata | input | DW | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | DW | Read data |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row/column/mode address |
| sd_dq_out | output | DW | Write data to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DW | Read data from the device |
| size_bytes | output | 32 | Device size in bytes |

## Verification
A command appears on `sd_cmd` one clock after the edge that accepts it. The bench logs each non-NOP command with its cycle number at the falling edge. Spacing checks compare the logged cycle numbers against the tRP, tRC, tRCD and tRAS+tRP values. Read data is captured CL edges after READ, so the bench presents its marker value only in the one cycle before that edge and shows junk on either side. `host_ready` is checked a short delay after the falling edge where it appears, and the refresh interval is checked as an exact difference of the logged cycle numbers.

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq #(
  parameter int AW = 28,
  parameter int DW = 32,
  parameter int TW = 4,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [1:0]    cfg_col,
  input  logic [1:0]    cfg_row,
  input  logic          cfg_bank,
  input  logic          cfg_dbw16,
  input  logic [2:0]    cfg_cas,
  input  logic [TW-1:0] cfg_twr,
  input  logic [TW-1:0] cfg_trc,
  input  logic [TW-1:0] cfg_trp,
  input  logic [TW-1:0] cfg_trcd,
  input  logic [TW-1:0] cfg_tras,
  input  logic [TW-1:0] cfg_txsr,
  input  logic [RW-1:0] ref_period,
  input  logic          host_sel,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic          host_ready,
  output logic [DW-1:0] host_rdata,
  output logic          sd_cke,
  output logic [3:0]    sd_cmd,
  output logic [1:0]    sd_ba,
  output logic [12:0]   sd_addr,
  output logic [DW-1:0] sd_dq_out,
  output logic          sd_dq_oe,
  input  logic [DW-1:0] sd_dq_in,
  output logic [31:0]   size_bytes
);
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100;
  localparam logic [2:0] M_NORM = 3'd0, M_NOP = 3'd1, M_PRE = 3'd2,
                         M_REF = 3'd3, M_MRS = 3'd4;
  localparam logic [AW-1:0] ONES = '1;

  typedef enum logic [2:0] {S_IDLE, S_ACT, S_RD, S_APRE, S_RPRE} st_t;

  function automatic logic [TW-1:0] ld(input logic [TW-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  st_t           st;
  logic [TW-1:0] wait_cnt, ras_cnt, rc_cnt;
  logic [2:0]    rd_cnt;
  logic [RW-1:0] ref_cnt;
  logic          ref_due;

  wire [5:0]    cb   = 6'd8 + 6'(cfg_col);
  wire [5:0]    rb   = 6'd11 + 6'(cfg_row);
  wire [5:0]    bb   = 6'd1 + 6'(cfg_bank);
  wire [AW-1:0] word = cfg_dbw16 ? host_addr >> 1 : host_addr >> 2;
  wire [AW-1:0] col  = word & ~(ONES << cb);
  wire [AW-1:0] row  = (word >> cb) & ~(ONES << rb);
  wire [AW-1:0] bank = (word >> (cb + rb)) & ~(ONES << bb);

  assign size_bytes = 32'd1 << (cb + rb + bb + (cfg_dbw16 ? 6'd1 : 6'd2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wait_cnt <= '0; ras_cnt <= '0; rc_cnt <= '0; rd_cnt <= '0;
      ref_cnt <= '0; ref_due <= 1'b0;
      host_ready <= 1'b0; host_rdata <= '0;
      sd_cke <= 1'b0; sd_cmd <= C_NOP; sd_ba <= '0; sd_addr <= '0;
      sd_dq_out <= '0; sd_dq_oe <= 1'b0;
    end else begin
      sd_cmd <= C_NOP;
      sd_dq_oe <= 1'b0;
      host_ready <= 1'b0;
      if (wait_cnt != '0) wait_cnt <= wait_cnt - 1'b1;
      if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
      if (rc_cnt != '0) rc_cnt <= rc_cnt - 1'b1;

      if (ref_period == '0 || mode != M_NORM || !sd_cke) begin
        ref_cnt <= '0;
        if (ref_period == '0) ref_due <= 1'b0;
      end else if (ref_cnt == ref_period - 1'b1) begin
        ref_cnt <= '0;
        ref_due <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end

      case (st)
        S_IDLE:
          if (ref_due && wait_cnt == '0 && rc_cnt == '0) begin
            sd_cmd <= C_PRE; sd_addr <= 13'h400; wait_cnt <= ld(cfg_trp); st <= S_RPRE;
          end else if (host_sel && !host_ready && wait_cnt == '0) begin
            if (!sd_cke) begin
              host_ready <= 1'b1; host_rdata <= '0;
              if (mode == M_NOP) begin sd_cke <= 1'b1; wait_cnt <= ld(cfg_txsr); end
            end else begin
              case (mode)
                M_NORM:
                  if (rc_cnt == '0) begin
                    sd_cmd <= C_ACT; sd_ba <= bank[1:0]; sd_addr <= row[12:0];
                    wait_cnt <= ld(cfg_trcd); ras_cnt <= ld(cfg_tras); rc_cnt <= ld(cfg_trc);
                    st <= S_ACT;
                  end
                M_PRE: begin
                  sd_cmd <= C_PRE; sd_addr <= 13'h400; wait_cnt <= ld(cfg_trp);
                  host_ready <= 1'b1; host_rdata <= '0;
                end
                M_REF:
                  if (rc_cnt == '0) begin
                    sd_cmd <= C_REF; wait_cnt <= ld(cfg_trc); rc_cnt <= ld(cfg_trc);
                    host_ready <= 1'b1; host_rdata <= '0;
                  end
                M_MRS: begin
                  sd_cmd <= C_MRS; sd_ba <= 2'b00; sd_addr <= 13'(cfg_cas) << 4;
                  wait_cnt <= ld(TW'(2)); host_ready <= 1'b1; host_rdata <= '0;
                end
                default: begin host_ready <= 1'b1; host_rdata <= '0; end
              endcase
            end
          end
        S_ACT:
          if (wait_cnt == '0) begin
            sd_addr <= {2'b00, 1'b1, col[9:0]};
            if (host_we) begin
              sd_cmd <= C_WR; sd_dq_out <= host_wdata; sd_dq_oe <= 1'b1;
              wait_cnt <= ld(cfg_twr); st <= S_APRE;
            end else begin
              sd_cmd <= C_RD; rd_cnt <= cfg_cas; st <= S_RD;
            end
          end
        S_RD: begin
          rd_cnt <= rd_cnt - 1'b1;
          if (rd_cnt <= 3'd1) begin host_rdata <= sd_dq_in; st <= S_APRE; end
        end
        S_APRE:
          if (wait_cnt == '0 && ras_cnt == '0) begin
            wait_cnt <= ld(cfg_trp); host_ready <= 1'b1; st <= S_IDLE;
          end
        S_RPRE:
          if (wait_cnt == '0) begin
            sd_cmd <= C_REF; wait_cnt <= ld(cfg_trc); rc_cnt <= ld(cfg_trc);
            ref_due <= 1'b0; st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sdram_cmd_seq_chk #(parameter int TW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          sd_cke,
  input logic [3:0]    sd_cmd,
  input logic          sd_dq_oe,
  input logic          host_ready,
  input logic [TW-1:0] cfg_trp,
  input logic [31:0]   size_bytes
);
  // R2
  cke_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cke |-> sd_cmd == 4'b0111);
  // R3
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  // R5
  precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_cmd == 4'b0010 && cfg_trp > 1) |=> sd_cmd == 4'b0111);
  // R7
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> sd_cmd == 4'b0100);
  // R12
  size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(size_bytes) == 1);
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cmd(sd_cmd), .sd_dq_oe(sd_dq_oe),
  .host_ready(host_ready), .cfg_trp(cfg_trp), .size_bytes(size_bytes));

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000, C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100;
  localparam int TRP = 3, TRC = 7, TRCD = 2, TRAS = 5, TWR = 2, CL = 2;
  localparam logic [31:0] MAGIC = 32'hC0DE_5A17, JUNK = 32'hDEAD_BEEF;
  // {mode, expected command}; NOP means no command expected
  localparam logic [6:0] VEC [11] = '{
    {3'd1, C_NOP}, {3'd2, C_PRE},
    {3'd3, C_REF}, {3'd3, C_REF}, {3'd3, C_REF}, {3'd3, C_REF},
    {3'd3, C_REF}, {3'd3, C_REF}, {3'd3, C_REF}, {3'd3, C_REF},
    {3'd4, C_MRS}};

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 3'd1;
  logic [1:0] cfg_col = 2'd1, cfg_row = 2'd2;
  logic cfg_bank = 1'b1, cfg_dbw16 = 1'b0;
  logic [2:0] cfg_cas = 3'(CL);
  logic [3:0] cfg_twr = 4'(TWR), cfg_trc = 4'(TRC), cfg_trp = 4'(TRP);
  logic [3:0] cfg_trcd = 4'(TRCD), cfg_tras = 4'(TRAS), cfg_txsr = 4'd4;
  logic [15:0] ref_period = '0;
  logic host_sel = 0, host_we = 0;
  logic [27:0] host_addr = '0;
  logic [31:0] host_wdata = '0, sd_dq_in = JUNK;
  logic host_ready, sd_cke, sd_dq_oe;
  logic [31:0] host_rdata, sd_dq_out, size_bytes;
  logic [3:0] sd_cmd;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  sdram_cmd_seq u_sdram_cmd_seq (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0, nlog = 0;
  logic [3:0] lcmd [64];
  logic [1:0] lba [64];
  logic [12:0] laddr [64];
  logic [31:0] ldq [64];
  logic loe [64];
  int lcyc [64];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && sd_cmd != C_NOP && nlog < 64) begin
    lcmd[nlog] = sd_cmd; lba[nlog] = sd_ba; laddr[nlog] = sd_addr;
    ldq[nlog] = sd_dq_out; loe[nlog] = sd_dq_oe; lcyc[nlog] = cyc; nlog = nlog + 1;
  end
  always @(negedge clk) if (rst_n && sd_cmd == C_RD) fork
    begin repeat (CL - 1) @(negedge clk); sd_dq_in = MAGIC; @(negedge clk); sd_dq_in = JUNK; end
  join_none

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] m, input logic we, input logic [27:0] a, input logic [31:0] d);
    @(negedge clk);
    mode = m; host_we = we; host_addr = a; host_wdata = d; host_sel = 1;
    do @(negedge clk); while (!host_ready);
    host_sel = 0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    logic [27:0] waddr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cke", sd_cke, 0);
    chk("R1 cmd", sd_cmd, C_NOP);
    chk("R1 ready", host_ready, 0);
    rst_n = 1;
    // R12 size: 9 col + 13 row + 2 bank, 32-bit
    chk("R12 size32", size_bytes, 32'd1 << 26);
    // R2 precharge before clock enable issues nothing
    access(3'd2, 0, '0, '0);
    repeat (2) @(negedge clk);
    chk("R2 no cmd", nlog, 0);
    chk("R2 cke off", sd_cke, 0);

    for (int i = 0; i < 11; i++) begin
      base = nlog;
      access(VEC[i][6:4], 0, '0, '0);
      repeat (1) @(negedge clk); #1;
      if (VEC[i][3:0] == C_NOP) begin
        chk("R2 cke on", sd_cke, 1);
        chk("R3 nop none", nlog - base, 0);
      end else begin
        chk("R3 one cmd", nlog - base, 1);
        chk("R3 cmd code", lcmd[base], VEC[i][3:0]);
        if (i == 1) chk("R3 pre a10", laddr[base][10], 1);
        if (i == 2) chk("R5 trp", lcyc[base] - lcyc[base-1], TRP);
        if (i > 2) chk("R5 trc", lcyc[base] - lcyc[base-1], TRC);
        if (i == 10) begin
          chk("R4 mrs addr", laddr[base], 13'(CL) << 4);
          chk("R4 mrs ba", lba[base], 0);
        end
      end
    end
    chk("R3 eight refs", nlog, 10);

    // R6 R7 normal write: bank 2, row 0x123, col 0x45
    waddr = 28'(((32'd2 << 22) | (32'h123 << 9) | 32'h45) << 2);
    base = nlog;
    access(3'd0, 1, waddr, 32'h1234_5678);
    chk("R6 act cmd", lcmd[base], C_ACT);
    chk("R6 row", laddr[base], 13'h123);
    chk("R6 bank", lba[base], 2);
    chk("R7 wr cmd", lcmd[base+1], C_WR);
    chk("R7 col a10", laddr[base+1], 13'h445);
    chk("R7 wdata", ldq[base+1], 32'h1234_5678);
    chk("R7 oe", loe[base+1], 1);
    chk("R5 trcd", lcyc[base+1] - lcyc[base], TRCD);
    // R8 normal read
    access(3'd0, 0, waddr, '0);
    chk("R8 rd cmd", lcmd[base+3], C_RD);
    chk("R8 rdata", host_rdata, MAGIC);
    chk("R5 act-act", (lcyc[base+2] - lcyc[base]) >= TRAS + TRP, 1);
    chk("R5 wr-act", (lcyc[base+2] - lcyc[base+1]) >= TWR + TRP, 1);
    // R9 non-normal read returns 0
    access(3'd1, 0, '0, '0);
    chk("R9 rdata zero", host_rdata, 0);

    // R10 periodic refresh
    @(negedge clk); mode = 3'd0; ref_period = 16'd40;
    base = nlog;
    repeat (100) @(negedge clk);
    chk("R10 pre", lcmd[base], C_PRE);
    chk("R10 pre a10", laddr[base][10], 1);
    chk("R10 ref", lcmd[base+1], C_REF);
    chk("R10 pre-ref", lcyc[base+1] - lcyc[base], TRP);
    chk("R10 ref period", lcyc[base+3] - lcyc[base+1], 40);
    // R11 disabled
    ref_period = '0;
    repeat (5) @(negedge clk);
    base = nlog;
    repeat (100) @(negedge clk);
    chk("R11 no refresh", nlog - base, 0);
    // R12 16-bit bus
    cfg_dbw16 = 1;
    @(negedge clk);
    chk("R12 size16", size_bytes, 32'd1 << 25);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule